// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is a small configuration register file that a host reaches through just two byte-wide I/O locations. One location is the index port and the other is the data port. The host issues single-cycle byte writes and reads on a plain strobe/address/data bus. The register file starts locked. It opens only after a fixed key byte is written to the index port twice in a row, and it closes again when a lock byte is written there.

While the block is open, the last byte written to the index port names a register, and data-port accesses read or write that register. One global register picks a logical device. Four per-device registers then act on the bank of the selected device:

- an enable bit,
- a 16-bit base address, reached as a high byte and a low byte,
- an interrupt-select byte.

The chip and vendor identification bytes are read-only and stay visible whatever device is selected. Every bank's contents are driven out in parallel, so the device logic that uses them can read them directly.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is locked, the index and device-select registers are 0x00, every bank's enable, base and interrupt-select are zero, and rdata_o is 0xFF.
- R2: The block opens (cfg_mode_o=1) only after two consecutive index-port (addr_i=0) writes of 0x87. Any other index-port write while locked restarts the key sequence. Data-port accesses do not affect the sequence.
- R3: While open, an index-port write of 0xAA locks the block and leaves the index register unchanged.
- R4: While locked, data-port and index-port reads return 0xFF, and data-port writes change no register.
- R5: While open, an index-port write of any value other than 0xAA stores that value as the register index, and an index-port read returns it.
- R6: Register 0x07 is the device select. With a device d below NUM_DEV selected, the following registers act on bank d, which drives dev_en_o[d], dev_base_o[16d+15:16d] and dev_irq_o[8d+7:8d]:
  - 0x30 is the enable, kept in bit 0, with the other bits reading 0;
  - 0x60 is the base high byte;
  - 0x61 is the base low byte;
  - 0x70 is the interrupt select.
- R7: Registers 0x20/0x21 return the CHIP_ID high/low bytes, and 0x22/0x23 return the vendor ID 0x5AC3 high/low bytes. They read the same under any device select, and writes to them are ignored.
- R8: When the device select is NUM_DEV or above, the bank registers read 0xFF and writes to them change no bank.
- R9: Any other register number reads 0x00, and writes to it change no register.
- R10: rdata_o loads on the clock edge at which rd_i is high and holds otherwise. When a read and a write fall in the same cycle, the read returns the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, registered |
| cfg_mode_o | output | 1 | Configuration mode open |
| dev_en_o | output | NUM_DEV | Per-device enable |
| dev_base_o | output | 16*NUM_DEV | Per-device base address |
| dev_irq_o | output | 8*NUM_DEV | Per-device interrupt select |

## Verification
A read and a write can land in the same cycle: a data-port read together with a data-port write to the same register, or an index-port read together with the lock write. The bench drives both strobes on one cycle. It expects the read to return the value from before the write, and a later read to show the write's effect. The random phase mixes key, lock, select and bank writes with reads against a bench model, and it applies every read before the write of the same cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_BYTE    = 8'h87;
  localparam logic [7:0] LOCK_BYTE   = 8'hAA;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_CHIP_HI = 8'h20;
  localparam logic [7:0] REG_CHIP_LO = 8'h21;
  localparam logic [7:0] REG_VND_HI  = 8'h22;
  localparam logic [7:0] REG_VND_LO  = 8'h23;
  localparam logic [7:0] REG_EN      = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] REG_IRQ     = 8'h70;
  localparam logic [15:0] VENDOR_ID  = 16'h5AC3;
  localparam int BASE_W = 16;
  localparam int IRQ_W  = 8;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: state_d = (wdata_i == KEY_BYTE) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   state_d = (wdata_i == KEY_BYTE) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   state_d = (wdata_i == LOCK_BYTE) ? ST_LOCKED : ST_OPEN;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        reg_i,
  input  logic [7:0]        wdata_i,
  output logic              en_o,
  output logic [BASE_W-1:0] base_o,
  output logic [IRQ_W-1:0]  irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      base_o <= '0;
      irq_o  <= '0;
    end else if (wr_i) begin
      unique case (reg_i)
        REG_EN:      en_o         <= wdata_i[0];
        REG_BASE_HI: base_o[15:8] <= wdata_i;
        REG_BASE_LO: base_o[7:0]  <= wdata_i;
        REG_IRQ:     irq_o        <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgp_rdmux.sv
module cfgp_rdmux
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] CHIP_ID = 16'h0C51
) (
  input  logic                      open_i,
  input  logic [7:0]                idx_i,
  input  logic [7:0]                ldn_i,
  input  logic [NUM_DEV-1:0]        en_i,
  input  logic [NUM_DEV*BASE_W-1:0] base_i,
  input  logic [NUM_DEV*IRQ_W-1:0]  irq_i,
  output logic [7:0]                val_o
);
  logic              hit;
  logic              sel_en;
  logic [BASE_W-1:0] sel_base;
  logic [IRQ_W-1:0]  sel_irq;

  always_comb begin
    hit      = 1'b0;
    sel_en   = 1'b0;
    sel_base = '0;
    sel_irq  = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (ldn_i == 8'(d)) begin
        hit      = 1'b1;
        sel_en   = en_i[d];
        sel_base = base_i[d*BASE_W +: BASE_W];
        sel_irq  = irq_i[d*IRQ_W +: IRQ_W];
      end
    end
  end

  always_comb begin
    val_o = 8'h00;
    if (!open_i) begin
      val_o = 8'hFF;
    end else begin
      unique case (idx_i)
        REG_LDN:     val_o = ldn_i;
        REG_CHIP_HI: val_o = CHIP_ID[15:8];
        REG_CHIP_LO: val_o = CHIP_ID[7:0];
        REG_VND_HI:  val_o = VENDOR_ID[15:8];
        REG_VND_LO:  val_o = VENDOR_ID[7:0];
        REG_EN:      val_o = hit ? {7'd0, sel_en} : 8'hFF;
        REG_BASE_HI: val_o = hit ? sel_base[15:8] : 8'hFF;
        REG_BASE_LO: val_o = hit ? sel_base[7:0] : 8'hFF;
        REG_IRQ:     val_o = hit ? sel_irq : 8'hFF;
        default:     val_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] CHIP_ID = 16'h0C51
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic                      addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output logic                      cfg_mode_o,
  output logic [NUM_DEV-1:0]        dev_en_o,
  output logic [NUM_DEV*BASE_W-1:0] dev_base_o,
  output logic [NUM_DEV*IRQ_W-1:0]  dev_irq_o
);
  logic       open;
  logic       idx_wr;
  logic       dat_wr;
  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic [7:0] data_val;

  assign idx_wr = wr_i & ~addr_i;
  assign dat_wr = wr_i & addr_i & open;

  cfgp_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .wdata_i  (wdata_i),
    .open_o   (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_wr && open && (wdata_i != LOCK_BYTE)) idx_q <= wdata_i;
      if (dat_wr && (idx_q == REG_LDN))             ldn_q <= wdata_i;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    cfgp_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (dat_wr && (ldn_q == 8'(d))),
      .reg_i   (idx_q),
      .wdata_i (wdata_i),
      .en_o    (dev_en_o[d]),
      .base_o  (dev_base_o[d*BASE_W +: BASE_W]),
      .irq_o   (dev_irq_o[d*IRQ_W +: IRQ_W])
    );
  end

  cfgp_rdmux #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_rdmux (
    .open_i (open),
    .idx_i  (idx_q),
    .ldn_i  (ldn_q),
    .en_i   (dev_en_o),
    .base_i (dev_base_o),
    .irq_i  (dev_irq_o),
    .val_o  (data_val)
  );

  // read captures pre-write state of the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'hFF;
    else if (rd_i) rdata_o <= addr_i ? data_val : (open ? idx_q : 8'hFF);
  end

  assign cfg_mode_o = open;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int NUM_DEV = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic                    addr_i,
  input logic [7:0]              wdata_i,
  input logic [7:0]              rdata_o,
  input logic                    cfg_mode_o,
  input logic [NUM_DEV-1:0]      dev_en_o,
  input logic [NUM_DEV*16-1:0]   dev_base_o,
  input logic [NUM_DEV*8-1:0]    dev_irq_o
);
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(wr_i && !addr_i && wdata_i == 8'h87)); // R2

  AST_LOCK_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && wr_i && !addr_i && wdata_i == 8'hAA) |=> !cfg_mode_o); // R3

  AST_LOCKED_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && rd_i) |=> (rdata_o == 8'hFF)); // R4

  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |=> ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_o))); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
endmodule

bind keyed_cfg_port cfgp_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .cfg_mode_o (cfg_mode_o),
  .dev_en_o   (dev_en_o),
  .dev_base_o (dev_base_o),
  .dev_irq_o  (dev_irq_o)
);

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam logic [15:0] CHIP = 16'h0C51;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0]      wdata_i = 8'h00;
  logic [7:0]      rdata_o;
  logic            cfg_mode_o;
  logic [ND-1:0]   dev_en_o;
  logic [ND*16-1:0] dev_base_o;
  logic [ND*8-1:0] dev_irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  int         m_st;
  logic [7:0] m_idx, m_ldn;
  logic       m_en   [ND];
  logic [15:0] m_base[ND];
  logic [7:0] m_irq  [ND];

  keyed_cfg_port #(.NUM_DEV(ND), .CHIP_ID(CHIP)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_st = 0; m_idx = 0; m_ldn = 0;
    for (int d = 0; d < ND; d++) begin
      m_en[d] = 0; m_base[d] = 0; m_irq[d] = 0;
    end
  endfunction

  function automatic logic [7:0] m_rd(logic a);
    int d;
    if (m_st != 2) return 8'hFF;
    if (!a) return m_idx;
    d = int'(m_ldn);
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h22: return 8'h5A;
      8'h23: return 8'hC3;
      8'h30: return (d < ND) ? {7'd0, m_en[d]} : 8'hFF;
      8'h60: return (d < ND) ? m_base[d][15:8] : 8'hFF;
      8'h61: return (d < ND) ? m_base[d][7:0] : 8'hFF;
      8'h70: return (d < ND) ? m_irq[d] : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_wr(logic a, logic [7:0] v);
    int d;
    if (!a) begin
      case (m_st)
        0: m_st = (v == 8'h87) ? 1 : 0;
        1: m_st = (v == 8'h87) ? 2 : 0;
        default: if (v == 8'hAA) m_st = 0; else m_idx = v;
      endcase
    end else if (m_st == 2) begin
      d = int'(m_ldn);
      if (m_idx == 8'h07) m_ldn = v;
      else if (d < ND) begin
        case (m_idx)
          8'h30: m_en[d] = v[0];
          8'h60: m_base[d][15:8] = v;
          8'h61: m_base[d][7:0] = v;
          8'h70: m_irq[d] = v;
          default: ;
        endcase
      end
    end
  endfunction

  // one bus cycle; optional read and write in the same cycle
  task automatic op(bit w, bit r, logic a, logic [7:0] v, string tag);
    logic [7:0] exp;
    exp = m_rd(a);
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = v;
    @(negedge clk_i);
    wr_i = 0; rd_i = 0;
    if (w) m_wr(a, v);
    if (r) chk({tag, " read"}, rdata_o, exp);
  endtask

  task automatic wi(logic [7:0] v); op(1, 0, 0, v, "wr"); endtask
  task automatic wd(logic [7:0] v); op(1, 0, 1, v, "wr"); endtask
  task automatic rd(logic a, string tag); op(0, 1, a, 8'h00, tag); endtask

  task automatic chk_outs(string tag);
    chk({tag, " mode"}, cfg_mode_o, m_st == 2);
    for (int d = 0; d < ND; d++) begin
      chk({tag, " en"}, dev_en_o[d], m_en[d]);
      chk({tag, " base"}, dev_base_o[d*16 +: 16], m_base[d]);
      chk({tag, " irq"}, dev_irq_o[d*8 +: 8], m_irq[d]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 rdata", rdata_o, 8'hFF);
    chk_outs("R1");

    // R4 locked: writes ignored, reads FF
    wi(8'h30); wd(8'h01); rd(1, "R4"); rd(0, "R4");
    chk_outs("R4 locked write");

    // R2 broken sequence
    wi(8'h87); wi(8'h55); wi(8'h87);
    chk("R2 not open", cfg_mode_o, 1'b0);
    wd(8'h00);  // data access does not break sequence
    wi(8'h87);
    chk("R2 open", cfg_mode_o, 1'b1);

    // R5 index write/read
    wi(8'h61); rd(0, "R5");

    // R7 ids, under two device selects, write ignored
    wi(8'h07); wd(8'h02);
    wi(8'h20); rd(1, "R7"); wi(8'h21); rd(1, "R7");
    wi(8'h22); rd(1, "R7"); wd(8'h11); rd(1, "R7 ro");
    wi(8'h23); rd(1, "R7");
    wi(8'h07); wd(8'h00); wi(8'h22); rd(1, "R7 ldn0");

    // R6 bank writes for each device
    for (int d = 0; d < ND; d++) begin
      wi(8'h07); wd(8'(d)); rd(1, "R6 ldn");
      wi(8'h30); wd(8'hFF); rd(1, "R6 en");
      wi(8'h60); wd(8'(8'h10 + d)); wi(8'h61); wd(8'(8'hA0 + d));
      wi(8'h70); wd(8'(8'h30 + d)); rd(1, "R6 irq");
      chk_outs("R6");
    end

    // R8 out-of-range device select
    wi(8'h07); wd(8'(ND));
    wi(8'h70); wd(8'h99); rd(1, "R8");
    wi(8'h30); rd(1, "R8"); chk_outs("R8");

    // R9 unmapped
    wi(8'h45); wd(8'h12); rd(1, "R9"); chk_outs("R9");

    // R10 simultaneous data read+write returns old value
    wi(8'h07); wd(8'h01); wi(8'h70);
    op(1, 1, 1, 8'h5C, "R10 same-cycle");
    rd(1, "R10 after");
    // R3 lock with simultaneous index read
    op(1, 1, 0, 8'hAA, "R3 same-cycle");
    chk("R3 locked", cfg_mode_o, 1'b0);
    rd(1, "R3");
    wi(8'h87); wi(8'h87); rd(0, "R3 index kept");

    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] v;
      int k;
      k = $urandom_range(0, 15);
      case ($urandom_range(0, 5))
        0: v = 8'h87;
        1: v = 8'hAA;
        default: begin
          case (k % 8)
            0: v = 8'h07; 1: v = 8'h20; 2: v = 8'h23; 3: v = 8'h30;
            4: v = 8'h60; 5: v = 8'h61; 6: v = 8'h70; default: v = 8'($urandom);
          endcase
        end
      endcase
      case ($urandom_range(0, 4))
        0: op(1, 0, 0, v, "R5 rnd");
        1: op(1, 0, 1, (k < 3) ? 8'($urandom_range(0, 5)) : 8'($urandom), "R6 rnd");
        2: op(0, 1, 1, 8'h00, "R6 rnd");
        3: op(0, 1, 0, 8'h00, "R5 rnd");
        default: op(1, 1, 1, 8'($urandom), "R10 rnd");
      endcase
      if (i % 50 == 0) chk_outs("R6 rnd");
    end
    chk_outs("R6 rnd end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule